// File: doc/BRIEF.md
# Buffered Synchronous Serial Transceiver

This block is a full-duplex clocked serial port that sits on a simple microcontroller register bus. It exchanges 8-bit words most-significant bit first: one bit leaves on the serial data output and one bit enters on the serial data input for every serial clock period. A small bank of buffer words serves both directions. Before a burst, software places the outgoing words in the bank. As each word completes, the word that came in replaces the word that went out in the same slot.

Software selects how many words make up a burst and whether the serial clock is generated internally from the bus clock or taken from a pin. It starts operation with a start bit. At the end of every burst the block raises a one-cycle interrupt. With the internal clock, the port then holds the serial clock until software touches the buffer. With an external clock the shifting never waits. Clearing the start bit stops the port after the current word finishes. Setting the inhibit bit stops it at once.

Top module: `sio_xcvr`

## Requirements
- R1: After reset the serial clock output and serial data output are 1, the interrupt is 0, and the control register reads 0x00 (busy clear, one-word burst, internal clock).
- R2: The serial clock idles high. The falling edge of the serial clock is the leading edge, and on it the next transmit bit appears on sd_o. The rising edge is the trailing edge, and on it sd_i is sampled. Both directions run MSB first.
- R3: A burst exchanges N = words field + 1 words, taken from slots 0 to N-1 in order. After each word's 8th rising edge, the received word is written back into the slot that word was sent from. Slots outside the burst keep their contents.
- R4: After the final word of a burst, irq_o is high for exactly one bus clock cycle.
- R5: With the internal clock and the start bit still 1, the port stays busy after a burst and produces no serial clock edge. A bus write to any buffer slot, inside or outside the burst, releases it, and the next burst begins again at slot 0.
- R6: With the external clock (control bit 5 = 1), shifting follows sck_i edges and never stalls. The next burst resends slot 0, which by then holds the last received word. sck_o stays high.
- R7: Between words and after the port stops, sd_o keeps the last bit it drove until the next leading edge.
- R8: Clearing the start bit in the middle of a word lets that word finish and be stored. Busy then clears, no further serial clock edges occur, and no interrupt is raised unless the word closed a burst.
- R9: A control write with the inhibit bit (bit 4) set clears busy by the next cycle and returns sck_o high. The partly shifted word is discarded.
- R10: The words field (bits 2:0) and the clock select (bit 5) accept a write only while the stored start bit and busy are both 0. Otherwise they keep their old values.
- R11: Register map: addresses 0 to 7 are the buffer slots. Address 8 is control: bits 2:0 hold the word count minus one, bit 3 is start, bit 4 is inhibit, bit 5 selects the external clock, and bit 6 is the read-only busy flag. Writing the control register with start = 1 and inhibit = 0 while busy is 0 starts a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internally generated serial clock, idle high |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| irq_o | output | 1 | Burst-complete pulse |

## Verification
The checker enforces several properties on every cycle. The interrupt lasts a single cycle. sd_o moves only on a leading edge. An inhibit write drops busy on the next cycle. The serial clock is high whenever the port is idle. The words field and clock select stay frozen while busy. Properties of that kind cannot show what data was exchanged, so the bench's scenarios have to cover the rest: MSB-first bit order, the write-back of received words into their slots, the stall and its release by a buffer write, resending the shared buffer under an external clock, and the word-granular graceful stop.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned SIO_DW = 8;

  typedef struct packed {
    logic lead;
    logic trail;
  } sio_edge_t;
endpackage

// File: rtl/sio_sck_gen.sv
module sio_sck_gen
  import sio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ext_sel_i,
  input  logic      run_i,
  input  logic      sck_i,
  output logic      sck_o,
  output sio_edge_t edge_o
);
  localparam int unsigned DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIVW-1:0] div_q;
  logic            sck_q;
  logic [2:0]      sync_q;
  logic            tick;

  assign tick = run_i && !ext_sel_i && (div_q == DIVW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], sck_i};
      if (!run_i || ext_sel_i) begin
        div_q <= '0;
        sck_q <= 1'b1;
      end else if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (ext_sel_i) begin
      edge_o.lead  = run_i && sync_q[2] && !sync_q[1];
      edge_o.trail = run_i && !sync_q[2] && sync_q[1];
    end else begin
      edge_o.lead  = tick && sck_q;
      edge_o.trail = tick && !sck_q;
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          sd_i,
  output logic          sd_o,
  output logic          in_word_o,
  output logic          word_done_o,
  output logic [DW-1:0] rx_word_o
);
  localparam int unsigned BCW = $clog2(DW);

  logic [BCW-1:0] bit_q;
  logic [DW-1:0]  sh_q;
  logic           sd_q;
  logic           in_q;

  assign word_done_o = trail_i && in_q && (bit_q == BCW'(DW - 1));
  assign rx_word_o   = {sh_q[DW-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      sh_q  <= '0;
      sd_q  <= 1'b1;
      in_q  <= 1'b0;
    end else if (clear_i) begin
      bit_q <= '0;
      in_q  <= 1'b0;
    end else begin
      if (lead_i) begin
        if (!in_q) begin
          sh_q <= tx_word_i;
          sd_q <= tx_word_i[DW-1];
          in_q <= 1'b1;
        end else begin
          sd_q <= sh_q[DW-1];
        end
      end
      if (trail_i && in_q) begin
        sh_q <= {sh_q[DW-2:0], sd_i};
        if (bit_q == BCW'(DW - 1)) begin
          bit_q <= '0;
          in_q  <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign sd_o      = sd_q;
  assign in_word_o = in_q;
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
  import sio_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned CLK_DIV   = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [$clog2(NUM_WORDS):0]          bus_addr_i,
  input  logic                                bus_we_i,
  input  logic [SIO_DW-1:0]                   bus_wdata_i,
  output logic [SIO_DW-1:0]                   bus_rdata_o,
  input  logic                                sck_i,
  output logic                                sck_o,
  input  logic                                sd_i,
  output logic                                sd_o,
  output logic                                irq_o
);
  localparam int unsigned CW      = $clog2(NUM_WORDS);
  localparam int unsigned AW      = CW + 1;
  localparam int unsigned START_B = CW;
  localparam int unsigned INH_B   = CW + 1;
  localparam int unsigned EXT_B   = CW + 2;
  localparam int unsigned BUSY_B  = CW + 3;

  logic [SIO_DW-1:0] buf_q [NUM_WORDS];
  logic [CW-1:0]     idx_q, words_q;
  logic              start_q, inh_q, ext_q, busy_q, wait_q, irq_q;
  logic              wr_buf, wr_ctrl, inh_req, run;
  logic              in_word, word_done, last_word, lead_ev;
  logic [SIO_DW-1:0] rx_word, tx_word;
  sio_edge_t         edge_s;

  assign wr_buf    = bus_we_i && (bus_addr_i < AW'(NUM_WORDS));
  assign wr_ctrl   = bus_we_i && (bus_addr_i == AW'(NUM_WORDS));
  assign inh_req   = wr_ctrl && bus_wdata_i[INH_B];
  assign run       = busy_q && !wait_q && (start_q || in_word);
  assign tx_word   = buf_q[idx_q];
  assign last_word = word_done && (idx_q == words_q);
  assign lead_ev   = edge_s.lead;

  sio_sck_gen #(.CLK_DIV(CLK_DIV)) i_sck_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_sel_i(ext_q),
    .run_i    (run),
    .sck_i    (sck_i),
    .sck_o    (sck_o),
    .edge_o   (edge_s)
  );

  sio_shift #(.DW(SIO_DW)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!busy_q),
    .lead_i     (edge_s.lead),
    .trail_i    (edge_s.trail),
    .tx_word_i  (tx_word),
    .sd_i       (sd_i),
    .sd_o       (sd_o),
    .in_word_o  (in_word),
    .word_done_o(word_done),
    .rx_word_o  (rx_word)
  );

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= '0;
      end else if (wr_buf && bus_addr_i[CW-1:0] == CW'(g)) begin
        buf_q[g] <= bus_wdata_i;
      end else if (word_done && idx_q == CW'(g)) begin
        buf_q[g] <= rx_word;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      inh_q   <= 1'b0;
      ext_q   <= 1'b0;
      words_q <= '0;
    end else if (wr_ctrl) begin
      start_q <= bus_wdata_i[START_B];
      inh_q   <= bus_wdata_i[INH_B];
      if (!start_q && !busy_q) begin
        words_q <= bus_wdata_i[CW-1:0];
        ext_q   <= bus_wdata_i[EXT_B];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= last_word;
      if (inh_req) begin
        busy_q <= 1'b0;
        wait_q <= 1'b0;
      end else if (!busy_q) begin
        if (wr_ctrl && bus_wdata_i[START_B]) begin
          busy_q <= 1'b1;
          wait_q <= 1'b0;
          idx_q  <= '0;
        end
      end else if (word_done) begin
        idx_q <= last_word ? '0 : idx_q + 1'b1;
        if (last_word && start_q && !ext_q) wait_q <= 1'b1;
      end else if (!start_q && !in_word) begin
        busy_q <= 1'b0;
        wait_q <= 1'b0;
      end else if (wait_q && wr_buf) begin
        wait_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i < AW'(NUM_WORDS)) begin
      bus_rdata_o = buf_q[bus_addr_i[CW-1:0]];
    end else if (bus_addr_i == AW'(NUM_WORDS)) begin
      bus_rdata_o[CW-1:0] = words_q;
      bus_rdata_o[START_B] = start_q;
      bus_rdata_o[INH_B]   = inh_q;
      bus_rdata_o[EXT_B]   = ext_q;
      bus_rdata_o[BUSY_B]  = busy_q;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_i,
  input logic          sck_i,
  input logic          sd_i,
  input logic          busy_i,
  input logic          lead_i,
  input logic          inh_req_i,
  input logic          ext_i,
  input logic [CW-1:0] words_i
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R4

  AST_SD_MOVES_ON_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lead_i |=> $stable(sd_i)); // R7

  AST_INHIBIT_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_req_i |=> !busy_i); // R9

  AST_SCK_HIGH_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> sck_i); // R2

  AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(words_i) && $stable(ext_i))); // R10
endmodule

bind sio_xcvr sio_xcvr_chk #(.CW(CW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .sck_i    (sck_o),
  .sd_i     (sd_o),
  .busy_i   (busy_q),
  .lead_i   (lead_ev),
  .inh_req_i(inh_req),
  .ext_i    (ext_q),
  .words_i  (words_q)
);

// File: tb/test_sio_xcvr.sv
module test_sio_xcvr;
  localparam int CTRL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_i = 1'b1;
  logic       sck_o, sd_i, sd_o, irq;
  logic       ext_mode = 1'b0;
  logic       ser_clk;
  logic [63:0] slv_tx = '0;
  logic [63:0] slv_rx = '0;
  int         rise_cnt = 0;
  int         irq_cnt = 0;
  int         total = 0;
  int         bad = 0;

  // {tx word, word returned by the far end}
  localparam logic [15:0] VEC [5] = '{16'hA53C, 16'h01FE, 16'hFE01, 16'h807F, 16'h00FF};

  always #10 clk = ~clk;

  sio_xcvr i_sio_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sck_i(sck_i), .sck_o(sck_o),
    .sd_i(sd_i), .sd_o(sd_o), .irq_o(irq)
  );

  assign ser_clk = ext_mode ? sck_i : sck_o;

  initial sd_i = 1'b1;
  always @(negedge ser_clk) begin
    sd_i   <= slv_tx[63];
    slv_tx <= slv_tx << 1;
  end
  always @(posedge ser_clk) begin
    slv_rx   <= {slv_rx[62:0], sd_o};
    rise_cnt <= rise_cnt + 1;
  end
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_irq(input int target);
    for (int n = 0; n < 4000 && irq_cnt < target; n++) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int n = 0; n < 2000; n++) begin
      rd(CTRL, v);
      if (!v[6]) break;
    end
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int r0, q0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sd_o", sd_o, 1);
    chk("R1 sck_o", sck_o, 1);
    chk("R1 irq", irq, 0);
    rd(CTRL, v); chk("R1 ctrl", v, 8'h00);

    // vector table: single-word bursts, internal clock
    for (int i = 0; i < 5; i++) begin
      slv_tx = {VEC[i][7:0], 56'h0};
      q0 = irq_cnt;
      wr(0, VEC[i][15:8]);
      wr(CTRL, 8'h08);
      wait_irq(q0 + 1);
      repeat (4) @(negedge clk);
      chk("R2 far end got MSB first", slv_rx[7:0], VEC[i][15:8]);
      rd(0, v); chk("R3 rx stored in slot 0", v, VEC[i][7:0]);
      chk("R4 one irq pulse", irq_cnt - q0, 1);
      r0 = rise_cnt;
      repeat (40) @(negedge clk);
      chk("R5 no clock while stalled", rise_cnt - r0, 0);
      rd(CTRL, v); chk("R5 busy while stalled", v[6], 1);
      chk("R7 sd_o holds last bit", sd_o, VEC[i][8]);
      wr(CTRL, 8'h00);
      wait_idle();
      rd(CTRL, v); chk("R8 busy clear after stop", v[6], 0);
    end

    // three-word burst, then stall release through slot 7
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44);
    slv_tx = {8'hAA, 8'hBB, 8'hCC, 40'h0};
    q0 = irq_cnt; r0 = rise_cnt;
    wr(CTRL, 8'h0A);
    wait_irq(q0 + 1);
    repeat (4) @(negedge clk);
    chk("R3 three words in order", slv_rx[23:0], 24'h112233);
    rd(0, v); chk("R3 slot0", v, 8'hAA);
    rd(1, v); chk("R3 slot1", v, 8'hBB);
    rd(2, v); chk("R3 slot2", v, 8'hCC);
    rd(3, v); chk("R3 slot3 untouched", v, 8'h44);
    chk("R3 24 clocks", rise_cnt - r0, 24);
    r0 = rise_cnt;
    wr(7, 8'h5A);
    wait_irq(q0 + 2);
    repeat (4) @(negedge clk);
    chk("R5 released burst resends slot 0", slv_rx[23:0], 24'hAABBCC);
    chk("R5 released burst length", rise_cnt - r0, 24);
    wr(CTRL, 8'h02);
    wait_idle();

    // graceful stop inside word 1 of a four-word burst
    wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h30); wr(3, 8'h40);
    slv_tx = {8'hC1, 8'hC2, 8'hC3, 8'hC4, 32'h0};
    q0 = irq_cnt; r0 = rise_cnt;
    wr(CTRL, 8'h0B);
    for (int n = 0; n < 4000 && rise_cnt - r0 < 11; n++) @(negedge clk);
    wr(CTRL, 8'h03);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R8 word finished then stop", rise_cnt - r0, 16);
    rd(0, v); chk("R8 slot0", v, 8'hC1);
    rd(1, v); chk("R8 finished word stored", v, 8'hC2);
    rd(2, v); chk("R8 slot2 untouched", v, 8'h30);
    chk("R8 no irq", irq_cnt - q0, 0);
    chk("R8 sck high", sck_o, 1);

    // inhibit mid-word, words field locked while busy
    wr(0, 8'h77); wr(1, 8'h66);
    slv_tx = {8'h99, 56'h0};
    r0 = rise_cnt;
    wr(CTRL, 8'h09);
    for (int n = 0; n < 4000 && rise_cnt - r0 < 4; n++) @(negedge clk);
    wr(CTRL, 8'h0D);
    rd(CTRL, v); chk("R10 words locked while busy", v[2:0], 3'd1);
    wr(CTRL, 8'h19);
    rd(CTRL, v); chk("R9 busy cleared", v[6], 0);
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    chk("R9 clock stopped", rise_cnt - r0, 0);
    chk("R9 sck high", sck_o, 1);
    rd(0, v); chk("R9 partial word discarded", v, 8'h77);
    wr(CTRL, 8'h00);
    wr(CTRL, 8'h05);
    rd(CTRL, v); chk("R11 words accepted when idle", v, 8'h05);

    // external clock, no stall, shared buffer resent
    wr(CTRL, 8'h20);
    ext_mode = 1'b1;
    wr(0, 8'h3C);
    slv_tx = {8'h96, 8'h0F, 48'h0};
    q0 = irq_cnt;
    wr(CTRL, 8'h28);
    ext_pulses(16);
    repeat (20) @(negedge clk);
    chk("R6 two bursts without stall", irq_cnt - q0, 2);
    chk("R6 second burst resends received word", slv_rx[15:0], 16'h3C96);
    rd(0, v); chk("R6 slot0 holds last rx", v, 8'h0F);
    chk("R6 sck_o idle", sck_o, 1);
    chk("R7 sd_o keeps last bit", sd_o, 0);
    wr(CTRL, 8'h20);
    wait_idle();
    rd(CTRL, v); chk("R11 ctrl after ext stop", v, 8'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule